// File: doc/BRIEF.md
# PLL Power-Up Sequencer

This block brings an analog PLL out of its parked state in a safe order when an enable request goes high. It drives three mode controls: one that takes the PLL out of bypass, an active-low reset, and an output gate. It puts a fixed number of microseconds between the steps. The microsecond tick comes from an internal prescaler, set by the number of input clock cycles per microsecond. Every wait is a whole number of these ticks, counted from the step that started it.

Three orderings are available, chosen when a sequence starts:
- The standard ordering leaves bypass first. It releases reset after a gap, then opens the output after a fixed lock wait.
- The alternate ordering releases reset first. It leaves bypass after the gap, then opens the output after a longer fixed wait.
- The polling ordering follows the standard steps up to reset release. It then samples the PLL lock indicator once per microsecond. It opens the output at the first sample that sees lock. If no sample sees lock within a bounded number of samples, it reports a timeout and keeps the output gated.

Dropping the request clears all three controls in the next cycle, whatever step the sequence has reached. A handoff status output reports whether the PLL is currently fully enabled.

Top module: `pllseq_top`

## Requirements
- R1: While rst_n is low, mode_o is 3'b000, and done_o, timeout_err_o and handoff_en_o are 0. This holds whatever the other inputs do.
- R2: The bits of mode_o have these meanings:
  - mode_o[0] is the output enable.
  - mode_o[1] is high when the PLL is not bypassed.
  - mode_o[2] is the PLL reset, active low, so 1 means released.
  
  handoff_en_o is high exactly when all three bits are 1. The output enable is never high unless the other two bits are high.
- R3: Standard ordering is selected by order_sel_i = 2'b00, and 2'b11 behaves the same. Let E be the clock edge at which en_req_i is first sampled high while idle, and let P be CLK_PER_US.
  - mode_o becomes 3'b010 at E.
  - It becomes 3'b110 at E + BYP_GAP_US*P.
  - It becomes 3'b111 at E + (BYP_GAP_US+STD_LOCK_US)*P.
- R4: Alternate ordering is selected by order_sel_i = 2'b01.
  - mode_o becomes 3'b100 at E.
  - It becomes 3'b110 at E + BYP_GAP_US*P.
  - It becomes 3'b111 at E + (BYP_GAP_US+ALT_LOCK_US)*P.
- R5: Polling ordering is selected by order_sel_i = 2'b10.
  - mode_o becomes 3'b010 at E, then 3'b110 at E + BYP_GAP_US*P.
  - lock_i is then sampled at the edges E + (BYP_GAP_US+i)*P, for i from 1 to POLL_SAMPLES.
  - mode_o becomes 3'b111 at the first of these edges at which lock_i is high. This includes the last sample.
  - lock_i is ignored at all other times and in the other orderings.
- R6: If no poll sample sees lock, mode_o stays at 3'b110 and timeout_err_o rises at edge E + (BYP_GAP_US+POLL_SAMPLES)*P. The output enable stays low.
- R7: If en_req_i is sampled low at any edge, mode_o is 3'b000 and done_o is 0 after that edge. This applies mid-sequence too: the sequence aborts without raising done_o.
- R8: done_o is a level that is high exactly while the sequence holds the output enabled. timeout_err_o clears at the next sequence start (edge E). Until then it stays high, including after the request drops.
- R9: order_sel_i is sampled only at edge E. Changes to it during a sequence have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_req_i | input | 1 | Enable request level |
| lock_i | input | 1 | Lock indicator from the analog PLL |
| order_sel_i | input | 2 | Ordering select: 00 standard, 01 alternate, 10 polling, 11 standard |
| mode_o | output | 3 | [0] output enable, [1] not-bypassed, [2] reset released (active-low reset) |
| done_o | output | 1 | High while the PLL output is enabled by the sequence |
| timeout_err_o | output | 1 | Lock poll budget exhausted without lock |
| handoff_en_o | output | 1 | All three mode controls set |

## Verification
The assertions assume only a few things:
- rst_n starts low.
- Every interval parameter is at least one.
- lock_i, en_req_i and order_sel_i are synchronous to clk.

None of the assertions constrains when the request falls or when lock arrives. The bench uses a small configuration and changes inputs only on the falling clock edge. It sweeps the following:
- every ordering;
- every cycle at which lock can first appear relative to the poll samples, including never;
- every cycle at which the request can be dropped.

During each sequence it scrambles order_sel_i, and outside polling it toggles lock_i.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  localparam int MODE_W    = 3;
  localparam int MODE_OUT  = 0;
  localparam int MODE_NBYP = 1;
  localparam int MODE_NRST = 2;

  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_GAP  = 3'd1,
    ST_WAIT = 3'd2,
    ST_ON   = 3'd3,
    ST_FAIL = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    ORD_STD  = 2'b00,
    ORD_ALT  = 2'b01,
    ORD_POLL = 2'b10
  } order_t;

  function automatic order_t decode_order(input logic [1:0] sel);
    case (sel)
      2'b01:   return ORD_ALT;
      2'b10:   return ORD_POLL;
      default: return ORD_STD;
    endcase
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pllseq_us_tick.sv
module pllseq_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (CLK_PER_US <= 1) begin : g_pass
      logic unused_restart;
      assign unused_restart = restart;
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(CLK_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             pc_q <= '0;
        else if (restart)       pc_q <= '0;
        else if (pc_q == LAST)  pc_q <= '0;
        else                    pc_q <= pc_q + 1'b1;
      end
      assign tick = (pc_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/pllseq_tick_count.sv
module pllseq_tick_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (tick)    cnt_q <= cnt_q + 1'b1;
  end

  assign last = tick && (cnt_q == (limit - 1'b1));
endmodule

// File: rtl/pllseq_top.sv
module pllseq_top
  import pllseq_pkg::*;
#(
  parameter int CLK_PER_US   = 100,
  parameter int BYP_GAP_US   = 10,
  parameter int STD_LOCK_US  = 50,
  parameter int ALT_LOCK_US  = 60,
  parameter int POLL_SAMPLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_req_i,
  input  logic              lock_i,
  input  logic [1:0]        order_sel_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              done_o,
  output logic              timeout_err_o,
  output logic              handoff_en_o
);
  localparam int MAX_US = max2(max2(BYP_GAP_US, STD_LOCK_US), max2(ALT_LOCK_US, POLL_SAMPLES));
  localparam int CW     = $clog2(MAX_US + 1);

  localparam logic [MODE_W-1:0] M_OFF  = '0;
  localparam logic [MODE_W-1:0] M_NBYP = MODE_W'(1) << MODE_NBYP;
  localparam logic [MODE_W-1:0] M_NRST = MODE_W'(1) << MODE_NRST;
  localparam logic [MODE_W-1:0] M_OUT  = MODE_W'(1) << MODE_OUT;
  localparam logic [MODE_W-1:0] M_BOTH = M_NBYP | M_NRST;
  localparam logic [MODE_W-1:0] M_ALL  = M_BOTH | M_OUT;

  seq_state_t        st_q, st_d;
  order_t            ord_q, ord_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              err_q, err_d;
  logic              restart, tick, last;
  logic [CW-1:0]     limit;

  pllseq_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick)
  );

  pllseq_tick_count #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(limit), .last(last)
  );

  always_comb begin
    limit = CW'(BYP_GAP_US);
    if (st_q == ST_WAIT) begin
      case (ord_q)
        ORD_ALT:  limit = CW'(ALT_LOCK_US);
        ORD_POLL: limit = CW'(POLL_SAMPLES);
        default:  limit = CW'(STD_LOCK_US);
      endcase
    end
  end

  always_comb begin
    st_d   = st_q;
    ord_d  = ord_q;
    mode_d = mode_q;
    err_d  = err_q;
    if (!en_req_i) begin
      st_d   = ST_OFF;
      mode_d = M_OFF;
    end else begin
      case (st_q)
        ST_OFF: begin
          st_d   = ST_GAP;
          ord_d  = decode_order(order_sel_i);
          err_d  = 1'b0;
          mode_d = (decode_order(order_sel_i) == ORD_ALT) ? M_NRST : M_NBYP;
        end
        ST_GAP: begin
          if (last) begin
            st_d   = ST_WAIT;
            mode_d = M_BOTH;
          end
        end
        ST_WAIT: begin
          if (ord_q == ORD_POLL) begin
            if (tick && lock_i) begin
              st_d   = ST_ON;
              mode_d = M_ALL;
            end else if (last) begin
              st_d  = ST_FAIL;
              err_d = 1'b1;
            end
          end else if (last) begin
            st_d   = ST_ON;
            mode_d = M_ALL;
          end
        end
        default: ;
      endcase
    end
  end

  assign restart = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OFF;
      ord_q  <= ORD_STD;
      mode_q <= M_OFF;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      ord_q  <= ord_d;
      mode_q <= mode_d;
      err_q  <= err_d;
    end
  end

  assign mode_o        = mode_q;
  assign done_o        = (st_q == ST_ON);
  assign timeout_err_o = err_q;
  assign handoff_en_o  = (mode_q == M_ALL);
endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_req_i,
  input logic [2:0] mode_o,
  input logic       done_o,
  input logic       timeout_err_o,
  input logic       handoff_en_o
);
  // R2: the output gate opens only with bypass left and reset released
  p_out_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o[0] |-> (mode_o[1] && mode_o[2]));

  // R3: one control rises per step, never two at once
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_o & ~$past(mode_o)) <= 1);

  // R7: a low request clears everything on the next edge
  p_drop_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req_i |=> (mode_o == 3'b000 && !done_o));

  // R6: a reported timeout never coexists with an open output
  p_err_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err_o |-> !mode_o[0]);

  // R8: done tracks the open output, which implies handoff status
  p_done_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o[0] |-> done_o) and (done_o |-> handoff_en_o));

  // R8: the error flag is cleared when a new sequence starts
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_o) == 3'b000 && mode_o != 3'b000) |-> !timeout_err_o);
endmodule

bind pllseq_top pllseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_req_i(en_req_i), .mode_o(mode_o),
  .done_o(done_o), .timeout_err_o(timeout_err_o), .handoff_en_o(handoff_en_o)
);

// File: tb/pllseq_top_tb_top.sv
module pllseq_top_tb_top;
  localparam int P    = 4;
  localparam int GAP  = 3;
  localparam int LK   = 5;
  localparam int ALT  = 6;
  localparam int POLL = 7;
  localparam int G    = GAP * P;
  localparam int TEND = G + POLL * P;
  localparam int L    = TEND + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_req_i = 1'b0;
  logic lock_i = 1'b0;
  logic [1:0] order_sel_i = 2'b00;
  logic [2:0] mode_o;
  logic done_o, timeout_err_o, handoff_en_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pllseq_top #(.CLK_PER_US(P), .BYP_GAP_US(GAP), .STD_LOCK_US(LK),
               .ALT_LOCK_US(ALT), .POLL_SAMPLES(POLL)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_req_i(en_req_i), .lock_i(lock_i),
    .order_sel_i(order_sel_i), .mode_o(mode_o), .done_o(done_o),
    .timeout_err_o(timeout_err_o), .handoff_en_o(handoff_en_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int seen_edge(input int lock_at);
    for (int i = 1; i <= POLL; i++)
      if (lock_at >= 0 && G + i * P - 1 >= lock_at) return G + i * P;
    return -1;
  endfunction

  function automatic int exp_mode(input int sel, input int lock_at, input int c);
    int se;
    if (c < G) return (sel == 1) ? 3'b100 : 3'b010;
    if (sel == 1) return (c < G + ALT * P) ? 3'b110 : 3'b111;
    if (sel == 2) begin
      se = seen_edge(lock_at);
      if (se >= 0 && c >= se) return 3'b111;
      return 3'b110;
    end
    return (c < G + LK * P) ? 3'b110 : 3'b111;
  endfunction

  function automatic int exp_err(input int sel, input int lock_at, input int c);
    if (sel != 2) return 0;
    if (seen_edge(lock_at) >= 0) return 0;
    return (c >= TEND) ? 1 : 0;
  endfunction

  // One sequence: start with sel, lock rising at cycle lock_at, request dropped after cycle ab
  task automatic run_seq(input int sel, input int lock_at, input int ab);
    int em, ee, last_err;
    string tg;
    tg = (sel == 1) ? "R4" : (sel == 2) ? "R5" : "R3";
    order_sel_i = 2'(sel);
    lock_i = 1'b0;
    en_req_i = 1'b1;
    last_err = 0;
    for (int c = 0; c <= L; c++) begin
      @(posedge clk); @(negedge clk);
      em = exp_mode(sel, lock_at, c);
      ee = exp_err(sel, lock_at, c);
      last_err = ee;
      check(tg, int'(mode_o), em);
      check("R8 done level", int'(done_o), (em == 7) ? 1 : 0);
      check("R2 handoff", int'(handoff_en_o), (em == 7) ? 1 : 0);
      check((sel == 2) ? "R6 timeout" : "R8 err clear", int'(timeout_err_o), ee);
      order_sel_i = 2'(c + 1);  // R9: scrambled select must be ignored
      if (sel == 2) lock_i = (lock_at >= 0 && c >= lock_at);
      else lock_i = c[0];         // R5: lock ignored outside polling
      if (c == ab) break;
    end
    en_req_i = 1'b0;
    lock_i = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R7 clear mode", int'(mode_o), 0);
    check("R7 no done", int'(done_o), 0);
    check("R8 err hold", int'(timeout_err_o), last_err);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    en_req_i = 1'b1;
    lock_i = 1'b1;
    order_sel_i = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 mode", int'(mode_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 err", int'(timeout_err_o), 0);
    check("R1 handoff", int'(handoff_en_o), 0);
    en_req_i = 1'b0;
    lock_i = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int s = 0; s < 4; s++) run_seq(s, -1, -1);
    for (int la = 0; la <= TEND; la++) run_seq(2, la, -1);
    run_seq(2, -1, -1);
    run_seq(0, -1, -1);   // R8: error cleared by the next start
    for (int s = 0; s < 3; s++)
      for (int ab = 0; ab <= L; ab++) run_seq(s, -1, ab);
    for (int ab = 0; ab <= L; ab += 5) run_seq(2, G + 2 * P, ab);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule